// File: doc/BRIEF.md
# Modem Handshake Status and Loopback Unit

This unit keeps the modem control and modem status state of a serial port. Four external handshake inputs (clear-to-send, data-set-ready, carrier detect, ring indicate) are resynchronised and held as the upper nibble of an 8-bit status byte. Each change of these lines sets a sticky change flag in the lower nibble. For ring indicate the flag marks only the trailing edge. The change flags stay set until a status read. Their OR is the modem interrupt condition.

A 5-bit control register drives the request-to-send and data-terminal-ready outputs. The register also holds two general-purpose output bits and a loopback enable. With loopback on, the status read value is built from the control bits instead of the pins, and the external handshake outputs are held inactive. Priority of interrupts and the data path belong to other blocks.

Top module: `mdm_status_top`

## Requirements
- R1: After reset, the status byte reads 0xB0, the control register reads 0x08, `msi_o` is 0, and `rts_o` and `dtr_o` are 0.
- R2: The status byte bit positions are carrier=7, ring=6, data-set-ready=5, clear-to-send=4. These bits follow the pins exactly SYNC_STAGES+1 clock edges after a pin change.
- R3: For carrier, data-set-ready and clear-to-send, a change of the synchronized line in either direction sets the change flag in bit 3, 1 and 0 respectively.
- R4: Bit 2 is set when ring indicate falls from 1 to 0. A rise of ring indicate does not set bit 2.
- R5: Change flags accumulate: a flag already set stays set until a status read, and new changes are OR-ed in.
- R6: A status read strobe outside loopback clears bits 3..0 at the next edge. The upper nibble is unaffected.
- R7: `msi_o` is the OR of the four stored change flags.
- R8: A control write stores bits 4..0 of the write data: loopback=4, out2=3, out1=2, rts=1, dtr=0. Bits 7..5 read back as 0.
- R9: Outside loopback, `rts_o` equals control bit 1 and `dtr_o` equals control bit 0. In loopback both are 0.
- R10: In loopback, the status read value is built from the control bits: out2 at bit 7, out1 at bit 6, dtr at bit 5, rts at bit 4. Bits 3..0 read as 0.
- R11: In loopback, the stored status keeps tracking the pins and a read strobe does not clear the stored change flags. They are visible once loopback is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control write data |
| ctrl_rdata_o | output | 8 | Control register read value |
| stat_rd_i | input | 1 | Status read strobe (clears change flags) |
| stat_rdata_o | output | 8 | Status read value |
| cts_i | input | 1 | Clear-to-send pin, asynchronous |
| dsr_i | input | 1 | Data-set-ready pin, asynchronous |
| dcd_i | input | 1 | Carrier detect pin, asynchronous |
| ri_i | input | 1 | Ring indicate pin, asynchronous |
| rts_o | output | 1 | Request-to-send output |
| dtr_o | output | 1 | Data-terminal-ready output |
| msi_o | output | 1 | Modem status interrupt condition |

## Verification
The bench builds the unit with SYNC_STAGES=3 instead of the default 2. It checks that the status nibble stays unchanged for exactly that many edges and changes on the next one, so an off-by-one in the synchronizer chain shows up. The table walk drives every line in both directions, including both ring edges. Directed cases cover accumulation across several pin changes, the three loopback mappings, and change flags that build up while loopback hides them.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int unsigned LINE_W = 4;
  localparam int unsigned CTRL_W = 5;
  localparam int unsigned BYTE_W = 8;

  // line nibble bit order (matches status byte upper nibble)
  localparam int unsigned LN_CTS = 0;
  localparam int unsigned LN_DSR = 1;
  localparam int unsigned LN_RI  = 2;
  localparam int unsigned LN_DCD = 3;

  // control bit positions
  localparam int unsigned CB_DTR  = 0;
  localparam int unsigned CB_RTS  = 1;
  localparam int unsigned CB_OUT1 = 2;
  localparam int unsigned CB_OUT2 = 3;
  localparam int unsigned CB_LOOP = 4;

  localparam logic [LINE_W-1:0] LINE_RST = 4'b1011;
  localparam logic [CTRL_W-1:0] CTRL_RST = 5'b01000;

  typedef logic [LINE_W-1:0] line_t;
  typedef logic [CTRL_W-1:0] ctrl_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] src;
    if (g == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stg_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= RST_VAL;
      else         stg_q[g] <= src;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= CTRL_RST;
    else if (we_i) ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  assign ctrl_o = ctrl_q;

  p_ctrl_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ctrl_q == $past(wdata_i[CTRL_W-1:0]));
  p_ctrl_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctrl_q));
endmodule

// File: rtl/mdm_status_reg.sv
module mdm_status_reg
  import mdm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  line_t line_i,
  input  logic  clr_i,
  output line_t line_o,
  output line_t delta_o
);
  line_t line_q, delta_q, chg;

  always_comb begin
    chg = line_q ^ line_i;
    // ring flag only on trailing edge
    chg[LN_RI] = line_q[LN_RI] & ~line_i[LN_RI];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= LINE_RST;
      delta_q <= '0;
    end else begin
      line_q  <= line_i;
      delta_q <= (clr_i ? '0 : delta_q) | chg;
    end
  end

  assign line_o  = line_q;
  assign delta_o = delta_q;

  p_ring_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_q[LN_RI] && line_i[LN_RI] && !delta_q[LN_RI]) |=> !delta_q[LN_RI]);
  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((delta_q & $past(delta_q)) == $past(delta_q)));
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && line_i == line_q) |=> delta_q == '0);
  p_dcd_change_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i[LN_DCD] != line_q[LN_DCD]) |=> delta_q[LN_DCD]);
endmodule

// File: rtl/mdm_read_mux.sv
module mdm_read_mux
  import mdm_pkg::*;
(
  input  ctrl_t             ctrl_i,
  input  line_t             line_i,
  input  line_t             delta_i,
  output logic [BYTE_W-1:0] rdata_o
);
  line_t loop_line;

  always_comb begin
    loop_line         = '0;
    loop_line[LN_DCD] = ctrl_i[CB_OUT2];
    loop_line[LN_RI]  = ctrl_i[CB_OUT1];
    loop_line[LN_DSR] = ctrl_i[CB_DTR];
    loop_line[LN_CTS] = ctrl_i[CB_RTS];
    if (ctrl_i[CB_LOOP]) rdata_o = {loop_line, {LINE_W{1'b0}}};
    else                 rdata_o = {line_i, delta_i};
  end
endmodule

// File: rtl/mdm_status_top.sv
module mdm_status_top
  import mdm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [BYTE_W-1:0] ctrl_wdata_i,
  output logic [BYTE_W-1:0] ctrl_rdata_o,
  input  logic              stat_rd_i,
  output logic [BYTE_W-1:0] stat_rdata_o,
  input  logic              cts_i,
  input  logic              dsr_i,
  input  logic              dcd_i,
  input  logic              ri_i,
  output logic              rts_o,
  output logic              dtr_o,
  output logic              msi_o
);
  ctrl_t ctrl;
  line_t pins, line_sync, line_q, delta_q;
  logic  loop_on;

  assign pins = {dcd_i, ri_i, dsr_i, cts_i};

  mdm_sync #(.W(LINE_W), .STAGES(SYNC_STAGES), .RST_VAL(LINE_RST)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (pins), .q_o (line_sync)
  );

  mdm_ctrl_reg u_ctrl (
    .clk_i (clk_i), .rst_ni (rst_ni), .we_i (ctrl_we_i),
    .wdata_i (ctrl_wdata_i), .ctrl_o (ctrl)
  );

  assign loop_on = ctrl[CB_LOOP];

  mdm_status_reg u_stat (
    .clk_i (clk_i), .rst_ni (rst_ni), .line_i (line_sync),
    .clr_i (stat_rd_i & ~loop_on), .line_o (line_q), .delta_o (delta_q)
  );

  mdm_read_mux u_mux (
    .ctrl_i (ctrl), .line_i (line_q), .delta_i (delta_q), .rdata_o (stat_rdata_o)
  );

  assign ctrl_rdata_o = {{(BYTE_W-CTRL_W){1'b0}}, ctrl};
  assign rts_o = ctrl[CB_RTS] & ~loop_on;
  assign dtr_o = ctrl[CB_DTR] & ~loop_on;
  assign msi_o = |delta_q;

  p_msi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loop_on |-> (msi_o == (|stat_rdata_o[LINE_W-1:0])));
  p_loop_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata_o[CB_LOOP] |-> (!rts_o && !dtr_o));
  p_loop_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata_o[CB_LOOP] |-> (stat_rdata_o[LINE_W-1:0] == '0));
endmodule

// File: tb/mdm_status_top_tb.sv
`timescale 1ns/1ps
module mdm_status_top_tb;
  localparam int unsigned STG = 3;

  logic       clk = 0, rst_n = 0;
  logic       we = 0, rd = 0;
  logic [7:0] wdata = 0, crd, srd;
  logic [3:0] pins = 4'b1011;  // {dcd, ri, dsr, cts}
  logic       rts, dtr, msi;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mdm_status_top #(.SYNC_STAGES(STG)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .ctrl_we_i (we), .ctrl_wdata_i (wdata),
    .ctrl_rdata_o (crd), .stat_rd_i (rd), .stat_rdata_o (srd),
    .cts_i (pins[0]), .dsr_i (pins[1]), .dcd_i (pins[2+1]), .ri_i (pins[2]),
    .rts_o (rts), .dtr_o (dtr), .msi_o (msi)
  );

  // {pins, expected status byte on read}
  localparam logic [11:0] VEC [8] = '{
    12'hBB0, 12'hFF0, 12'hBB4, 12'h338,
    12'h221, 12'h002, 12'h999, 12'hFF2
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic set_pins(input logic [3:0] p);
    pins = p;
    repeat (STG + 1) step();
  endtask

  task automatic do_read(output logic [7:0] v);
    rd = 1; v = srd; step(); rd = 0;
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    wdata = v; we = 1; step(); we = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    step();
    // R1 reset state
    chk("R1 status", srd, 8'hB0);
    chk("R1 ctrl", crd, 8'h08);
    chk("R1 msi/rts/dtr", {5'b0, msi, rts, dtr}, 8'h00);

    // R2 R3 R4 R6 R7 table walk
    for (int i = 0; i < 8; i++) begin
      set_pins(VEC[i][11:8]);
      chk("R7 msi table", {7'b0, msi}, {7'b0, |VEC[i][3:0]});
      do_read(v);
      chk("R2/R3/R4 table", v, VEC[i][7:0]);
    end

    // R5 accumulate across changes
    set_pins(4'b1110);
    set_pins(4'b1111);
    chk("R5 msi held", {7'b0, msi}, 8'h01);
    set_pins(4'b1101);
    do_read(v);
    chk("R5 accumulate", v, 8'hD3);
    // R6 cleared
    chk("R6 msi cleared", {7'b0, msi}, 8'h00);
    chk("R6 after clear", srd, 8'hD0);

    // R2 exact latency
    pins = 4'b1100;
    repeat (STG) step();
    chk("R2 not yet", srd, 8'hD0);
    step();
    chk("R2 arrived", srd, 8'hC1);
    do_read(v);

    // R8 R9 control
    wr_ctrl(8'hE3);
    chk("R8 masked", crd, 8'h03);
    chk("R9 outputs", {6'b0, rts, dtr}, 8'h03);

    // R9 R10 loopback
    wr_ctrl(8'h1F);
    chk("R9 loop quiet", {6'b0, rts, dtr}, 8'h00);
    chk("R10 all", srd, 8'hF0);
    wr_ctrl(8'h15);
    chk("R10 out1 dtr", srd, 8'h60);
    wr_ctrl(8'h1A);
    chk("R10 out2 rts", srd, 8'h90);

    // R11 stored state tracks pins, loop read does not clear
    set_pins(4'b1101);
    chk("R11 msi in loop", {7'b0, msi}, 8'h01);
    do_read(v);
    chk("R11 loop read", v, 8'h90);
    wr_ctrl(8'h00);
    chk("R11 flags kept", srd, 8'hD1);
    chk("R9 idle", {6'b0, rts, dtr}, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule